// File: doc/BRIEF.md
# Windowed Bidirectional Bit-Bank Shift Register

This block holds a bank of single-bit cells, 256 by default. A window inside the bank is picked at run time by a head index and a length. Only the bits inside that window move when a shift happens. The shift runs toward higher indices (forward) or toward lower indices (reverse). The bit at the open end of the window is loaded from a serial data input. The bit pushed out of the closed end is dropped.

A shift happens once for each leading edge of a level pulse input. The pulse is registered on the system clock, and its edge is found by comparing two samples in a row. A synchronous window-clear input zeroes the window and overrides any shift in the same cycle. The whole bank is visible at all times on a parallel output. If the requested window runs past the top of the bank, it is clipped and a flag reports the clip.

Top module: `bitbank_shift_window`

## Requirements
- R1: While rst_ni is low, every bit of bank_o is 0. This is also the state after power-up.
- R2: The window covers indices head_i through min(head_i+len_i-1, 255). head_i ranges over 0..255 and len_i over 1..256. A len_i of 0 selects an empty window, and then neither a shift nor a clear changes any bit.
- R3: A shift happens only when the registered pulse_i sample is 1 and the sample before it is 0. If pulse_i is driven high before clock edge A, bank_o changes on the next edge B. A pulse held high gives no further shifts.
- R4: With dir_i=0 (forward), every window bit moves from index k to k+1. data_i enters at head_i, and the old bit at the last window index is dropped.
- R5: With dir_i=1 (reverse), every window bit moves from index k to k-1. data_i enters at the last window index, and the old bit at head_i is dropped.
- R6: With clr_i high at a clock edge, every window bit becomes 0. A pulse edge seen in that cycle is dropped and is not carried over to a later cycle.
- R7: A shift or a clear never changes a bit outside the window.
- R8: clip_o is 1 exactly when head_i+len_i > 256. In that case the window ends at index 255. clip_o follows head_i and len_i directly, with no clock delay.
- R9: With a window length of 1, a shift in either direction just loads data_i into head_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the whole bank |
| clr_i | input | 1 | Synchronous clear of the window bits |
| pulse_i | input | 1 | Level shift request; its leading edge causes one shift |
| dir_i | input | 1 | 0 forward (toward higher index), 1 reverse |
| data_i | input | 1 | Serial bit loaded at the open end of the window |
| head_i | input | 8 | Window head index |
| len_i | input | 9 | Window length, 0..256 |
| bank_o | output | 256 | Parallel view of the whole bank |
| clip_o | output | 1 | Window was clipped at the top of the bank |

## Verification
The properties rebuild the expected shift instant from the past two values of pulse_i. This only matches the internal edge detector if pulse_i is held low while rst_ni is low, because the detector registers are cleared by reset rather than loaded from the pin. The properties also assume that head_i, len_i, dir_i and data_i are valid at the clock edge where the shift lands. The bench drives every input on the falling clock edge and keeps pulse_i low throughout reset. Its random phase draws a fresh window, direction, data bit, pulse level and occasional clear on every cycle, and does so only after reset is released.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/srw_pulse_edge.sv
module srw_pulse_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic edge_o
);
  logic cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= pulse_i;
      prev_q <= cur_q;
    end
  end

  assign edge_o = cur_q & ~prev_q;
endmodule

// File: rtl/srw_window_decode.sv
module srw_window_decode #(
  parameter int BANK_W = 256,
  localparam int IDX_W = $clog2(BANK_W),
  localparam int LEN_W = IDX_W + 1,
  localparam int EXT_W = LEN_W + 1
) (
  input  logic [IDX_W-1:0]  head_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BANK_W-1:0] in_win_o,
  output logic [BANK_W-1:0] head_hit_o,
  output logic [BANK_W-1:0] tail_hit_o,
  output logic              clip_o
);
  logic [EXT_W-1:0] end_ext;
  logic [IDX_W-1:0] last_idx;
  logic             win_on;

  assign end_ext  = EXT_W'(head_i) + EXT_W'(len_i);
  assign clip_o   = end_ext > EXT_W'(BANK_W);
  assign win_on   = len_i != '0;
  assign last_idx = clip_o ? IDX_W'(BANK_W - 1) : IDX_W'(end_ext - EXT_W'(1));

  for (genvar k = 0; k < BANK_W; k++) begin : g_dec
    localparam logic [IDX_W-1:0] K = IDX_W'(k);
    assign in_win_o[k]   = win_on && (K >= head_i) && (K <= last_idx);
    assign head_hit_o[k] = win_on && (K == head_i);
    assign tail_hit_o[k] = win_on && (K == last_idx);
  end
endmodule

// File: rtl/srw_bank_next.sv
module srw_bank_next
  import srw_pkg::*;
#(
  parameter int BANK_W = 256
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BANK_W-1:0] in_win_i,
  input  logic [BANK_W-1:0] head_hit_i,
  input  logic [BANK_W-1:0] tail_hit_i,
  input  shift_dir_e        dir_i,
  input  logic              data_i,
  output logic [BANK_W-1:0] shift_o,
  output logic [BANK_W-1:0] clear_o
);
  for (genvar k = 0; k < BANK_W; k++) begin : g_cell
    logic lower_nb, upper_nb, fwd_v, rev_v;
    if (k == 0) begin : g_lo
      assign lower_nb = 1'b0;
    end else begin : g_lo
      assign lower_nb = bank_i[k-1];
    end
    if (k == BANK_W - 1) begin : g_hi
      assign upper_nb = 1'b0;
    end else begin : g_hi
      assign upper_nb = bank_i[k+1];
    end
    assign fwd_v = head_hit_i[k] ? data_i : lower_nb;
    assign rev_v = tail_hit_i[k] ? data_i : upper_nb;
    always_comb begin
      if (!in_win_i[k])          shift_o[k] = bank_i[k];
      else if (dir_i == DIR_FWD) shift_o[k] = fwd_v;
      else                       shift_o[k] = rev_v;
    end
    assign clear_o[k] = bank_i[k] & ~in_win_i[k];
  end
endmodule

// File: rtl/bitbank_shift_window.sv
module bitbank_shift_window
  import srw_pkg::*;
#(
  parameter int BANK_W = 256,
  localparam int IDX_W = $clog2(BANK_W),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pulse_i,
  input  logic              dir_i,
  input  logic              data_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              clip_o
);
  logic              shift_en;
  logic [BANK_W-1:0] bank_q, in_win, head_hit, tail_hit, shift_nx, clear_nx;

  srw_pulse_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .edge_o (shift_en)
  );

  srw_window_decode #(.BANK_W(BANK_W)) u_dec (
    .head_i    (head_i),
    .len_i     (len_i),
    .in_win_o  (in_win),
    .head_hit_o(head_hit),
    .tail_hit_o(tail_hit),
    .clip_o    (clip_o)
  );

  srw_bank_next #(.BANK_W(BANK_W)) u_next (
    .bank_i    (bank_q),
    .in_win_i  (in_win),
    .head_hit_i(head_hit),
    .tail_hit_i(tail_hit),
    .dir_i     (shift_dir_e'(dir_i)),
    .data_i    (data_i),
    .shift_o   (shift_nx),
    .clear_o   (clear_nx)
  );

  // clear wins; an edge in a clear cycle is consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (clr_i)    bank_q <= clear_nx;
    else if (shift_en) bank_q <= shift_nx;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int BANK_W = 256,
  localparam int IDX_W = $clog2(BANK_W),
  localparam int LEN_W = IDX_W + 1,
  localparam int EXT_W = LEN_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              pulse_i,
  input logic              dir_i,
  input logic              data_i,
  input logic [IDX_W-1:0]  head_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [BANK_W-1:0] bank_o,
  input logic              clip_o
);
  logic [EXT_W-1:0]  ext;
  logic [IDX_W-1:0]  tail;
  logic [BANK_W:0]   lim_hi;
  logic [BANK_W-1:0] one_v, lo_mask, keep_mask;
  logic              over;

  assign ext    = EXT_W'(head_i) + EXT_W'(len_i);
  assign over   = ext > EXT_W'(BANK_W);
  assign tail   = over ? IDX_W'(BANK_W - 1) : IDX_W'(ext - EXT_W'(1));
  assign one_v  = BANK_W'(1);
  assign lo_mask = (one_v << head_i) - one_v;
  assign lim_hi = ((BANK_W+1)'(1) << (32'(tail) + 1)) - (BANK_W+1)'(1);
  assign keep_mask = (len_i == '0) ? '1 : (lo_mask | ~lim_hi[BANK_W-1:0]);

  a_r8_clip_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clip_o == over);

  a_r3_no_edge_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !($past(pulse_i) && !$past(pulse_i, 2))) |=> $stable(bank_o));

  a_r4_fwd_head_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !dir_i && len_i != '0 && $past(pulse_i) && !$past(pulse_i, 2))
    |=> bank_o[$past(head_i)] == $past(data_i));

  a_r5_rev_tail_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dir_i && len_i != '0 && $past(pulse_i) && !$past(pulse_i, 2))
    |=> bank_o[$past(tail)] == $past(data_i));

  a_r6_clear_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && len_i != '0) |=> (bank_o[$past(head_i)] == 1'b0 && bank_o[$past(tail)] == 1'b0));

  a_r7_outside_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((bank_o ^ $past(bank_o)) & $past(keep_mask)) == '0);
endmodule

bind bitbank_shift_window srw_checker #(.BANK_W(BANK_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .pulse_i(pulse_i),
  .dir_i  (dir_i),
  .data_i (data_i),
  .head_i (head_i),
  .len_i  (len_i),
  .bank_o (bank_o),
  .clip_o (clip_o)
);

// File: tb/sim_bitbank_shift_window.sv
module sim_bitbank_shift_window;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0, pulse = 1'b0, dir = 1'b0, data = 1'b0;
  logic [7:0]   head = '0;
  logic [8:0]   len = 9'd1;
  logic [255:0] bank;
  logic         clip;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  logic  bg_on = 1'b0;
  logic [255:0] ref_bank = '0;
  logic rs0 = 1'b0, rs1 = 1'b0;

  always #2 clk = ~clk;

  bitbank_shift_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .pulse_i(pulse), .dir_i(dir),
    .data_i(data), .head_i(head), .len_i(len), .bank_o(bank), .clip_o(clip)
  );

  function automatic int last_of(input logic [7:0] h, input logic [8:0] l);
    int t = int'(h) + int'(l) - 1;
    return (t > 255) ? 255 : t;
  endfunction

  function automatic logic [255:0] m_shift(input logic [255:0] b, input logic d,
      input logic [7:0] h, input logic [8:0] l, input logic rv);
    logic [255:0] r = b;
    int lst = last_of(h, l);
    if (l == 0) return b;
    for (int k = int'(h); k <= lst; k++)
      if (!rv) r[k] = (k == int'(h)) ? d : b[k-1];
      else     r[k] = (k == lst) ? d : b[k+1];
    return r;
  endfunction

  function automatic logic [255:0] m_clear(input logic [255:0] b,
      input logic [7:0] h, input logic [8:0] l);
    logic [255:0] r = b;
    if (l == 0) return b;
    for (int k = int'(h); k <= last_of(h, l); k++) r[k] = 1'b0;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_bank <= '0; rs0 <= 1'b0; rs1 <= 1'b0;
    end else begin
      if (clr)                ref_bank <= m_clear(ref_bank, head, len);
      else if (rs0 && !rs1)   ref_bank <= m_shift(ref_bank, data, head, len, dir);
      rs0 <= pulse; rs1 <= rs0;
    end
  end

  always @(negedge clk) if (bg_on && rst_n) begin
    n_chk++;
    if (bank !== ref_bank) begin
      n_bad++;
      $display("FAIL %s bank act=%h exp=%h", cur_req, bank, ref_bank);
    end
    n_chk++;
    if (clip !== ((int'(head) + int'(len)) > 256)) begin
      n_bad++;
      $display("FAIL R8 clip act=%b exp=%b", clip, !clip);
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic shift_op(input logic d_dir, input logic [7:0] h, input logic [8:0] l, input logic d);
    @(negedge clk);
    dir = d_dir; head = h; len = l; data = d; pulse = 1'b1;
    repeat (2) @(negedge clk);
    pulse = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_op(input logic [7:0] h, input logic [8:0] l);
    @(negedge clk);
    head = h; len = l; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", bank, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", bank, '0);
    bg_on = 1'b1;

    cur_req = "R4";
    shift_op(1'b0, 8'd10, 9'd4, 1'b1);
    shift_op(1'b0, 8'd10, 9'd4, 1'b0);
    shift_op(1'b0, 8'd10, 9'd4, 1'b1);
    chk("R4", 256'(bank[13:10]), 256'(4'b0101));
    shift_op(1'b0, 8'd10, 9'd4, 1'b0);
    shift_op(1'b0, 8'd10, 9'd4, 1'b0);
    chk("R4", 256'(bank[14:10]), 256'(5'b00100));

    cur_req = "R3";
    @(negedge clk);
    dir = 1'b0; head = 8'd10; len = 9'd4; data = 1'b1; pulse = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3", 256'(bank[13:10]), 256'(4'b1001));
    pulse = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R7";
    shift_op(1'b0, 8'd9, 9'd1, 1'b1);
    shift_op(1'b0, 8'd14, 9'd1, 1'b1);
    clear_op(8'd10, 9'd4);
    chk("R7", 256'(bank[14:9]), 256'(6'b100001));

    cur_req = "R6";
    shift_op(1'b0, 8'd10, 9'd4, 1'b1);
    chk("R6", 256'(bank[13:10]), 256'(4'b0001));
    @(negedge clk);
    clr = 1'b1; pulse = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", 256'(bank[14:9]), 256'(6'b100001));
    pulse = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R5";
    shift_op(1'b1, 8'd100, 9'd3, 1'b1);
    shift_op(1'b1, 8'd100, 9'd3, 1'b0);
    shift_op(1'b1, 8'd100, 9'd3, 1'b0);
    chk("R5", 256'(bank[102:99]), 256'(4'b0010));
    shift_op(1'b1, 8'd100, 9'd3, 1'b0);
    chk("R5", 256'(bank[103:99]), 256'(5'b00000));

    cur_req = "R8";
    @(negedge clk);
    head = 8'd250; len = 9'd10; #1;
    chk("R8", 256'(clip), 256'(1'b1));
    len = 9'd6; #1;
    chk("R8", 256'(clip), 256'(1'b0));
    len = 9'd7; #1;
    chk("R8", 256'(clip), 256'(1'b1));
    shift_op(1'b1, 8'd250, 9'd10, 1'b1);
    chk("R8", 256'(bank[255:249]), 256'(7'b1000000));
    shift_op(1'b0, 8'd250, 9'd10, 1'b0);
    chk("R8", 256'(bank[255:249]), 256'(7'b0000000));

    cur_req = "R9";
    shift_op(1'b0, 8'd200, 9'd1, 1'b1);
    chk("R9", 256'(bank[201:199]), 256'(3'b010));
    shift_op(1'b1, 8'd200, 9'd1, 1'b0);
    chk("R9", 256'(bank[201:199]), 256'(3'b000));

    cur_req = "R2";
    snap = bank;
    shift_op(1'b0, 8'd50, 9'd0, 1'b1);
    clear_op(8'd9, 9'd0);
    chk("R2", bank, snap);
    shift_op(1'b0, 8'd0, 9'd256, 1'b1);
    chk("R2", bank, {snap[254:0], 1'b1});

    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      head  = 8'($urandom % 256);
      len   = 9'($urandom % 257);
      dir   = 1'($urandom % 2);
      data  = 1'($urandom % 2);
      pulse = 1'($urandom % 2);
      clr   = ($urandom % 16) == 0;
    end
    @(negedge clk);
    clr = 1'b0; pulse = 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    bg_on = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", bank, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule